// File: doc/BRIEF.md
# Single-Wire Parity Chunk Link

This block moves one framed chunk of bits over a single shared open wire. The wire is modelled as three signals: an output enable, an output value and the resolved line level that comes back. An external pull-up makes the line read high whenever nobody drives it. One instance can act as sender or as receiver, chosen per operation. Deciding who owns the wire, turning the direction around and sequencing several chunks into a transaction are the job of the logic above it.

A sender frame is built in this order. The line is driven low for one bit period and then high for one bit period. The data bits follow, most significant first. An even-parity bit comes next. The sender then drives the line low and keeps it low, so that the next frame starts with a clean rising edge. A receiver waits for the line to go low, but only for a bounded time, and then waits for it to go high. It times every bit from that rising edge and samples each one at mid-period. It reports the chunk together with a parity-mismatch flag. A chunk is either eight bits wide, for data, or seven bits wide, for an identifier. The bit period, the half period and the low-wait bound are parameters counted in clock cycles.

Top module: `swl_link`

## Requirements
- R1: After reset the line is released (`line_oe`=0), and `busy`, `done`, `rx_data` and `parity_err` are all 0.
- R2: After a send start accepted at clock edge E0, `line_oe` is 1 and `line_out` is 0 for BIT_CYC cycles. `line_out` is then 1 for BIT_CYC cycles. After that, each data bit is held for BIT_CYC cycles, most significant first: data bit k starts at edge E0+(2+k)·BIT_CYC.
- R3: The bit after the last data bit is the parity bit. It is held for BIT_CYC cycles and equals the XOR of the data bits sent, so the data bits plus parity bit always contain an even number of ones.
- R4: At the end of the parity bit, `line_out` goes to 0 with `line_oe` still 1, and `done` is 1 for exactly one cycle. The line stays driven low until a receive start is accepted.
- R5: The `wide` input is sampled when a start is accepted. `wide`=1 selects an 8-bit chunk `tx_data[7:0]`. `wide`=0 selects a 7-bit chunk `tx_data[6:0]`, and in that case received data is right-aligned with `rx_data[7]`=0.
- R6: In receive mode the block waits for a low level and then a high level on the line. It samples every bit at the middle of its period, with the first data bit one and a half bit periods after the rising edge. It delivers the bits MSB first in `rx_data` and raises `done` for one cycle when the parity bit is sampled.
- R7: `parity_err` is 1 exactly when the sampled parity bit differs from the XOR of the sampled data bits. The data is delivered either way. `rx_data` and `parity_err` change only in a cycle where `done` is 1.
- R8: If the line does not go low within TMO_PER·BIT_CYC cycles of an accepted receive start, the receiver proceeds as if the rising edge happened at that point. With the line held high, `done` appears TMO_PER·BIT_CYC+1+BIT_CYC+HALF_CYC+N·BIT_CYC cycles after the start edge, where N is the chunk width.
- R9: A `start` pulse while `busy` is 1 is ignored, as are changes to `tx_mode`, `wide` and `tx_data` after acceptance. Sending and receiving are never active together.
- R10: From the cycle after a receive start is accepted, the line is released (`line_oe`=0) for the whole receive operation.
- R11: `busy` is 1 from the cycle after a start is accepted until the cycle in which `done` is 1. It is 0 in that `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when idle |
| tx_mode | input | 1 | 1 = send a chunk, 0 = receive a chunk |
| wide | input | 1 | 1 = 8-bit chunk, 0 = 7-bit chunk |
| tx_data | input | DW | Chunk to send, MSB first |
| line_in | input | 1 | Resolved level of the shared wire |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Level driven when enabled |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rx_data | output | DW | Last received chunk, right-aligned |
| parity_err | output | 1 | Parity mismatch of the last received chunk |

## Verification
The assertions assume that `start` is only meaningful while the block is idle, and that the line level is a clean digital value once it has passed the two-flop synchronizer. The stimulus keeps every received frame on exact bit-period boundaries and keeps the wire low between frames, the way a real sender leaves it. As a result, the only rising edge the receiver sees is the frame's own sync edge. The stimulus holds the line high only in the timeout runs, and in those runs the release and the expiry of the wait bound are the behaviour under test.

// File: rtl/swl_pkg.sv
package swl_pkg;
  typedef enum logic [2:0] {
    TX_IDLE,
    TX_SYNC_LO,
    TX_SYNC_HI,
    TX_DATA,
    TX_PAR
  } tx_st_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_WAIT_LO,
    RX_WAIT_HI,
    RX_SAMPLE
  } rx_st_e;
endpackage

// File: rtl/swl_sync2.sv
module swl_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] ff;

  // Resets to 1: an idle wire reads high through the pull-up.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= 2'b11;
    else        ff <= {ff[0], d};
  end

  assign q = ff[1];
endmodule

// File: rtl/swl_tx.sv
module swl_tx
  import swl_pkg::*;
#(
  parameter int DW      = 8,
  parameter int BIT_CYC = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          release_i,
  input  logic          wide,
  input  logic [DW-1:0] data,
  output logic          oe,
  output logic          out,
  output logic          busy,
  output logic          done
);
  localparam int CW  = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int BCW = $clog2(DW + 1);

  tx_st_e         st_q, st_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [DW-1:0]  sh_q, sh_n;
  logic [BCW-1:0] nb_q, nb_n;
  logic           par_q, par_n;
  logic           oe_q, oe_n;
  logic           out_q, out_n;
  logic           done_q, done_n;
  logic           tick;

  assign tick = (cnt_q == CW'(BIT_CYC - 1));

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    nb_n   = nb_q;
    par_n  = par_q;
    oe_n   = oe_q;
    out_n  = out_q;
    done_n = 1'b0;
    if (st_q == TX_IDLE) begin
      if (go) begin
        st_n  = TX_SYNC_LO;
        cnt_n = '0;
        oe_n  = 1'b1;
        out_n = 1'b0;
        sh_n  = wide ? data : {data[DW-2:0], 1'b0};
        par_n = wide ? ^data : ^data[DW-2:0];
        nb_n  = wide ? BCW'(DW) : BCW'(DW - 1);
      end else if (release_i) begin
        oe_n = 1'b0;
      end
    end else if (tick) begin
      cnt_n = '0;
      case (st_q)
        TX_SYNC_LO: begin
          st_n  = TX_SYNC_HI;
          out_n = 1'b1;
        end
        TX_SYNC_HI: begin
          st_n  = TX_DATA;
          out_n = sh_q[DW-1];
          sh_n  = sh_q << 1;
          nb_n  = nb_q - BCW'(1);
        end
        TX_DATA: begin
          if (nb_q == '0) begin
            st_n  = TX_PAR;
            out_n = par_q;
          end else begin
            out_n = sh_q[DW-1];
            sh_n  = sh_q << 1;
            nb_n  = nb_q - BCW'(1);
          end
        end
        default: begin
          st_n   = TX_IDLE;
          out_n  = 1'b0;
          done_n = 1'b1;
        end
      endcase
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      nb_q   <= '0;
      par_q  <= 1'b0;
      oe_q   <= 1'b0;
      out_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      nb_q   <= nb_n;
      par_q  <= par_n;
      oe_q   <= oe_n;
      out_q  <= out_n;
      done_q <= done_n;
    end
  end

  assign oe   = oe_q;
  assign out  = out_q;
  assign busy = (st_q != TX_IDLE);
  assign done = done_q;

  // R2: the sender owns the wire for the whole frame
  a_r2_tx_owns_line: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> oe);
  // R4: a finished frame leaves the wire driven low
  a_r4_tx_ends_low: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (oe && !out));
  // R2: the period counter stays inside one bit period
  a_r2_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BIT_CYC - 1));
endmodule

// File: rtl/swl_rx.sv
module swl_rx
  import swl_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BIT_CYC  = 96,
  parameter int HALF_CYC = 48,
  parameter int TMO_PER  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wide,
  input  logic          line,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          perr
);
  localparam int TMO = TMO_PER * BIT_CYC;
  localparam int TW  = $clog2(TMO + 1);
  localparam int SW  = $clog2(BIT_CYC + HALF_CYC + 1);
  localparam int BCW = $clog2(DW + 1);

  rx_st_e         st_q, st_n;
  logic [TW-1:0]  tcnt_q, tcnt_n;
  logic [SW-1:0]  scnt_q, scnt_n;
  logic [DW-1:0]  sh_q, sh_n;
  logic [BCW-1:0] nb_q, nb_n;
  logic           wide_q, wide_n;
  logic [DW-1:0]  data_q, data_n;
  logic           perr_q, perr_n;
  logic           done_q, done_n;

  always_comb begin
    st_n   = st_q;
    tcnt_n = tcnt_q;
    scnt_n = scnt_q;
    sh_n   = sh_q;
    nb_n   = nb_q;
    wide_n = wide_q;
    data_n = data_q;
    perr_n = perr_q;
    done_n = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (go) begin
          st_n   = RX_WAIT_LO;
          tcnt_n = '0;
          wide_n = wide;
          sh_n   = '0;
        end
      end
      RX_WAIT_LO: begin
        if (!line || (tcnt_q == TW'(TMO - 1))) st_n = RX_WAIT_HI;
        else                                   tcnt_n = tcnt_q + TW'(1);
      end
      RX_WAIT_HI: begin
        if (line) begin
          st_n   = RX_SAMPLE;
          scnt_n = SW'(BIT_CYC + HALF_CYC - 1);
          nb_n   = wide_q ? BCW'(DW) : BCW'(DW - 1);
        end
      end
      default: begin
        if (scnt_q == '0) begin
          if (nb_q == '0) begin
            st_n   = RX_IDLE;
            data_n = sh_q;
            perr_n = line ^ (^sh_q);
            done_n = 1'b1;
          end else begin
            sh_n   = {sh_q[DW-2:0], line};
            nb_n   = nb_q - BCW'(1);
            scnt_n = SW'(BIT_CYC - 1);
          end
        end else begin
          scnt_n = scnt_q - SW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      scnt_q <= '0;
      sh_q   <= '0;
      nb_q   <= '0;
      wide_q <= 1'b0;
      data_q <= '0;
      perr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      tcnt_q <= tcnt_n;
      scnt_q <= scnt_n;
      sh_q   <= sh_n;
      nb_q   <= nb_n;
      wide_q <= wide_n;
      data_q <= data_n;
      perr_q <= perr_n;
      done_q <= done_n;
    end
  end

  assign busy = (st_q != RX_IDLE);
  assign done = done_q;
  assign data = data_q;
  assign perr = perr_q;

  // R7: results move only together with the done pulse
  a_r7_perr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(perr_q) |-> done_q);
  a_r7_data_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> done_q);
  // R8: the low-wait never runs past its bound
  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt_q <= TW'(TMO - 1));
  // R5: a 7-bit chunk keeps the top result bit clear
  a_r5_narrow_top: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !wide_q) |-> !data_q[DW-1]);
endmodule

// File: rtl/swl_link.sv
module swl_link #(
  parameter int DW       = 8,
  parameter int BIT_CYC  = 96,
  parameter int HALF_CYC = BIT_CYC / 2,
  parameter int TMO_PER  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tx_mode,
  input  logic          wide,
  input  logic [DW-1:0] tx_data,
  input  logic          line_in,
  output logic          line_oe,
  output logic          line_out,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_data,
  output logic          parity_err
);
  logic s_line;
  logic accept, tx_go, rx_go;
  logic tx_busy, rx_busy, tx_done, rx_done;

  assign accept = start & ~busy;
  assign tx_go  = accept & tx_mode;
  assign rx_go  = accept & ~tx_mode;

  swl_sync2 u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_in),
    .q     (s_line)
  );

  swl_tx #(.DW(DW), .BIT_CYC(BIT_CYC)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (tx_go),
    .release_i (rx_go),
    .wide      (wide),
    .data      (tx_data),
    .oe        (line_oe),
    .out       (line_out),
    .busy      (tx_busy),
    .done      (tx_done)
  );

  swl_rx #(.DW(DW), .BIT_CYC(BIT_CYC), .HALF_CYC(HALF_CYC), .TMO_PER(TMO_PER)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (rx_go),
    .wide  (wide),
    .line  (s_line),
    .busy  (rx_busy),
    .done  (rx_done),
    .data  (rx_data),
    .perr  (parity_err)
  );

  assign busy = tx_busy | rx_busy;
  assign done = tx_done | rx_done;

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11: the done cycle is already idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10: a receiving block never drives the wire
  a_r10_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
    rx_busy |-> !line_oe);
  // R9: send and receive never overlap
  a_r9_one_role: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_busy));
endmodule

// File: tb/sim_swl_link.sv
module sim_swl_link;
  localparam int CLK_P   = 10;
  localparam int DW      = 8;
  localparam int BIT     = 8;
  localparam int HALF    = 4;
  localparam int TMO_PER = 5;
  localparam int TMO     = TMO_PER * BIT;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          tx_mode;
  logic          wide;
  logic [DW-1:0] tx_data;
  logic          tb_drv;
  wire           line_in;
  logic          line_oe, line_out, busy, done, parity_err;
  logic [DW-1:0] rx_data;

  int total = 0;
  int bad   = 0;
  int done_cnt = 0;
  logic [DW-1:0] cap_d;
  logic          cap_e;

  assign line_in = line_oe ? line_out : tb_drv;

  swl_link #(.DW(DW), .BIT_CYC(BIT), .HALF_CYC(HALF), .TMO_PER(TMO_PER)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_mode(tx_mode), .wide(wide),
    .tx_data(tx_data), .line_in(line_in), .line_oe(line_oe), .line_out(line_out),
    .busy(busy), .done(done), .rx_data(rx_data), .parity_err(parity_err)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (done) begin
      done_cnt = done_cnt + 1;
      cap_d = rx_data;
      cap_e = parity_err;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ones_par(input int v, input int n);
    int p = 0;
    for (int i = 0; i < n; i++) p = p ^ ((v >> i) & 1);
    return p;
  endfunction

  task automatic run_tx(input int v, input bit w, input bit poke);
    int n = w ? 8 : 7;
    int d = w ? (v & 8'hFF) : (v & 8'h7F);
    int p = ones_par(d, n);
    int exp_fr = (1 << (n + 1)) | (d << 1) | p;
    int got_fr = 0;
    bit own_ok = 1'b1;
    bit busy_ok;
    @(negedge clk);
    start = 1'b1; tx_mode = 1'b1; wide = w; tx_data = v[DW-1:0];
    done_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    busy_ok = busy;
    for (int c = 0; c <= (3 + n) * BIT; c++) begin
      if (c > 0) @(negedge clk);
      if (poke && c == 20) begin
        start = 1'b1; tx_mode = 1'b0; tx_data = '0; wide = ~w;
      end else begin
        start = 1'b0;
      end
      if (c < (3 + n) * BIT) begin
        if (!line_oe || done) own_ok = 1'b0;
        if ((c % BIT) == HALF) got_fr = (got_fr << 1) | int'(line_out);
      end else begin
        chk(done && !line_out && line_oe, "R4 end low with done",
            {done, line_out, line_oe}, 3'b101);
        chk(!busy && busy_ok, "R11 busy span", {busy_ok, busy}, 2'b10);
      end
    end
    chk(got_fr == exp_fr, w ? "R2 frame 8-bit" : "R5 frame 7-bit", got_fr, exp_fr);
    chk((got_fr & 1) == p, "R3 even parity bit", got_fr & 1, p);
    chk(own_ok, "R2 line owned through frame", own_ok, 1);
    if (poke) begin
      @(negedge clk);
      chk(done_cnt == 1 && line_oe, "R9 start while busy ignored",
          done_cnt, 1);
    end
  endtask

  task automatic run_rx(input int v, input bit w, input bit flip);
    int n = w ? 8 : 7;
    int d = w ? (v & 8'hFF) : (v & 8'h7F);
    int p = ones_par(d, n) ^ int'(flip);
    bit rel_ok;
    @(negedge clk);
    start = 1'b1; tx_mode = 1'b0; wide = w; tx_data = ~v[DW-1:0];
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    done_cnt = 0;
    rel_ok = !line_oe;
    repeat (3) @(negedge clk);
    tb_drv = 1'b0; repeat (BIT) @(negedge clk);
    tb_drv = 1'b1; repeat (BIT) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      tb_drv = (d >> i) & 1;
      if (line_oe) rel_ok = 1'b0;
      repeat (BIT) @(negedge clk);
    end
    tb_drv = p[0]; repeat (BIT) @(negedge clk);
    tb_drv = 1'b0; repeat (2) @(negedge clk);
    chk(rel_ok, "R10 line released in receive", rel_ok, 1);
    chk(done_cnt == 1, "R6 one done per chunk", done_cnt, 1);
    chk(int'(cap_d) == d, w ? "R6 rx data 8-bit" : "R5 rx data 7-bit", cap_d, d);
    chk(cap_e == flip, "R7 parity flag", cap_e, flip);
  endtask

  task automatic run_tmo(input bit w);
    int n = w ? 8 : 7;
    int exp_c = TMO + 1 + BIT + HALF + n * BIT;
    int c = 0;
    @(negedge clk);
    start = 1'b1; tx_mode = 1'b0; wide = w;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && c < 400) begin
      @(negedge clk);
      c++;
    end
    chk(c == exp_c, "R8 timeout then sample", c, exp_c);
    chk(int'(rx_data) == ((1 << n) - 1), "R8 high line reads ones", rx_data, (1 << n) - 1);
    chk(parity_err == (n % 2 == 0), "R7 parity on ones", parity_err, n % 2 == 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tx_mode = 1'b0; wide = 1'b1;
    tx_data = '0; tb_drv = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!line_oe && !busy && !done && rx_data == '0 && !parity_err, "R1 reset state",
        {line_oe, busy, done, parity_err}, 0);
    // R8 bounded low-wait on an idle-high wire
    run_tmo(1'b1);
    run_tmo(1'b0);
    // R6/R7 receive sweeps; the wire rests low between frames
    tb_drv = 1'b0;
    for (int v = 0; v < 256; v++) run_rx(v, 1'b1, (v % 3) == 0);
    for (int v = 0; v < 128; v++) run_rx(v, 1'b0, (v % 5) == 0);
    // R2/R3/R5 send sweeps
    for (int v = 0; v < 256; v++) run_tx(v, 1'b1, 1'b0);
    for (int v = 0; v < 128; v++) run_tx(v, 1'b0, 1'b0);
    // R9 start pulse during a send
    run_tx(8'hA5, 1'b1, 1'b1);
    run_tx(8'h3C, 1'b0, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule